// File: doc/BRIEF.md
# MDIO Link Status Poller

This block runs a background scan of the management bus. It stays quiet until software sets its enable bit. After that it visits every PHY address from 0 to 31 in a fixed loop. At each address it asks a serial frame engine, over a valid/ready request and a one-cycle response, to read register 1 of that PHY, which is the basic status register. When the read returns, the block records two things in per-address bit vectors: whether the PHY acknowledged, and whether its link is up.

Two monitor entries each name one PHY address. For each entry, a source-select bit chooses the link state to watch. That state is either the polled link bit of the named address or a dedicated external link input. A change in the watched state latches a raw event bit. Each entry has an interrupt-enable bit that gates the raw bit onto a masked view and onto the interrupt line.

The poller shares the bus with host-issued transactions. It starts no new poll while a user transaction is pending. It also observes the completion of user reads, so that a host read also refreshes the alive bit of the address it targeted. A small word-addressed read/write port exposes the configuration and the status vectors.

Top module: `mdio_link_poller`

## Requirements
- R1: No poll request is raised while the enable bit (register 0, bit 0) is clear; after reset every register reads 0 and no request is pending.
- R2: While enabled, requests target PHY addresses in ascending order, wrapping from 31 to 0, and always name register 1. Clearing the enable and setting it again resumes from the next address.
- R3: After a poll response, bit N of the link vector (register 2) equals the acknowledge flag ANDed with bit 2 of the returned data, where N is the polled address.
- R4: After a poll response, bit N of the alive vector (register 1) equals the acknowledge flag, so the bit is set on an acknowledge and cleared on a missing one.
- R5: A completed user read sets or clears the alive bit of its target address according to its acknowledge flag.
- R6: Writing register 1 clears each alive bit written as 1; bits written as 0 are unchanged.
- R7: No new poll request starts while a user transaction is pending; polling resumes once it is no longer pending.
- R8: Monitor entry k sits at register 5+k, with the PHY address in bits 4:0, the source-select in bit 6 and the interrupt enable in bit 7. When source-select is 1, the watched state is external input k; when it is 0, the watched state is the link-vector bit of the named address.
- R9: A change in the watched state of entry k sets bit k of the raw event register (register 3). That bit stays set until software writes 1 to it.
- R10: The masked register (register 4) is the raw bits gated by each entry's interrupt enable, and the interrupt output is high when any masked bit is set.
- R11: A raised request holds its address steady until it is accepted by ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| req_valid_o | output | 1 | Poll read request to frame engine |
| req_ready_i | input | 1 | Frame engine accepts request |
| req_phy_o | output | 5 | Polled PHY address |
| req_reg_o | output | 5 | Polled PHY register (always 1) |
| resp_valid_i | input | 1 | Poll response strobe |
| resp_ack_i | input | 1 | PHY acknowledged the poll |
| resp_data_i | input | 16 | Returned status word |
| user_pending_i | input | 1 | A user transaction is waiting or running |
| user_done_i | input | 1 | A user read completed this cycle |
| user_phy_i | input | 5 | Address of the completed user read |
| user_ack_i | input | 1 | Acknowledge of the completed user read |
| ext_link_i | input | 2 | External link state per monitor entry |
| link_irq_o | output | 1 | Link-change interrupt |

## Verification
A corrupted scan counter shows up on the first accepted request after the fault, as an address out of order on req_phy_o. A wrong alive or link bit becomes visible in the vector registers only after the next response for that address, which can take a full pass of 32 polls. A stuck or missed watched-state register in a monitor entry appears as a raw event bit that is wrong one cycle after the underlying change. If the interrupt enable is gated wrongly, the masked register and link_irq_o disagree with the raw bits in that same cycle.

// File: rtl/mlp_pkg.sv
package mlp_pkg;
  typedef enum logic [1:0] {SCAN_IDLE, SCAN_REQ, SCAN_WAIT} scan_state_e;

  localparam int REG_AW     = 3;
  localparam int REG_W      = 32;
  localparam int A_CTRL     = 0;
  localparam int A_ALIVE    = 1;
  localparam int A_LINK     = 2;
  localparam int A_RAW      = 3;
  localparam int A_MASKED   = 4;
  localparam int A_SEL0     = 5;
  localparam int SEL_SRC_B  = 6;
  localparam int SEL_IEN_B  = 7;
endpackage

// File: rtl/mlp_scan_fsm.sv
module mlp_scan_fsm #(
  parameter int NUM_PHY  = 32,
  parameter int STAT_REG = 1,
  parameter int LINK_BIT = 2,
  parameter int DATA_W   = 16,
  localparam int AW      = $clog2(NUM_PHY)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              user_pending_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [AW-1:0]     req_phy_o,
  output logic [4:0]        req_reg_o,
  input  logic              resp_valid_i,
  input  logic              resp_ack_i,
  input  logic [DATA_W-1:0] resp_data_i,
  output logic              upd_valid_o,
  output logic [AW-1:0]     upd_phy_o,
  output logic              upd_ack_o,
  output logic              upd_link_o
);
  import mlp_pkg::*;

  scan_state_e   state_q;
  logic [AW-1:0] addr_q, addr_nxt;

  assign addr_nxt = (addr_q == AW'(NUM_PHY-1)) ? '0 : addr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SCAN_IDLE;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        SCAN_IDLE: if (enable_i && !user_pending_i) state_q <= SCAN_REQ;
        SCAN_REQ:  if (req_ready_i) state_q <= SCAN_WAIT;
        SCAN_WAIT: if (resp_valid_i) begin
          state_q <= SCAN_IDLE;
          addr_q  <= addr_nxt;
        end
        default:   state_q <= SCAN_IDLE;
      endcase
    end
  end

  assign req_valid_o = (state_q == SCAN_REQ);
  assign req_phy_o   = addr_q;
  assign req_reg_o   = 5'(STAT_REG);
  assign upd_valid_o = (state_q == SCAN_WAIT) && resp_valid_i;
  assign upd_phy_o   = addr_q;
  assign upd_ack_o   = resp_ack_i;
  // unacknowledged read counts as link down
  assign upd_link_o  = resp_ack_i & resp_data_i[LINK_BIT];

  AST_START_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> $past(enable_i)); // R1
  AST_START_NO_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> !$past(user_pending_i)); // R7
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_phy_o)); // R11
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |=> req_phy_o == (($past(req_phy_o) == AW'(NUM_PHY-1)) ? '0
                                  : $past(req_phy_o) + 1'b1)); // R2
endmodule

// File: rtl/mlp_status_vec.sv
module mlp_status_vec #(
  parameter int NUM_PHY = 32,
  localparam int AW     = $clog2(NUM_PHY)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_valid_i,
  input  logic [AW-1:0]      upd_phy_i,
  input  logic               upd_ack_i,
  input  logic               upd_link_i,
  input  logic               user_done_i,
  input  logic [AW-1:0]      user_phy_i,
  input  logic               user_ack_i,
  input  logic               clr_we_i,
  input  logic [NUM_PHY-1:0] clr_mask_i,
  output logic [NUM_PHY-1:0] alive_o,
  output logic [NUM_PHY-1:0] link_o
);
  logic [NUM_PHY-1:0] alive_q, alive_d, link_q, link_d;

  always_comb begin
    alive_d = alive_q;
    link_d  = link_q;
    if (clr_we_i) alive_d = alive_d & ~clr_mask_i;
    if (upd_valid_i) begin
      alive_d[upd_phy_i] = upd_ack_i;
      link_d[upd_phy_i]  = upd_link_i;
    end
    if (user_done_i) alive_d[user_phy_i] = user_ack_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alive_q <= '0;
      link_q  <= '0;
    end else begin
      alive_q <= alive_d;
      link_q  <= link_d;
    end
  end

  assign alive_o = alive_q;
  assign link_o  = link_q;

  AST_ALIVE_FOLLOWS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && !clr_we_i && !(user_done_i && user_phy_i == upd_phy_i)
    |=> alive_o[$past(upd_phy_i)] == $past(upd_ack_i)); // R4
  AST_LINK_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && !upd_ack_i |=> !link_o[$past(upd_phy_i)]); // R3
  AST_USER_ALIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_done_i && !clr_we_i |=> alive_o[$past(user_phy_i)] == $past(user_ack_i)); // R5
  AST_ALIVE_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i && !upd_valid_i && !user_done_i |=> (alive_o & $past(clr_mask_i)) == '0); // R6
endmodule

// File: rtl/mlp_link_monitor.sv
module mlp_link_monitor #(
  parameter int NUM_PHY = 32,
  parameter int NUM_MON = 2,
  localparam int AW     = $clog2(NUM_PHY)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_PHY-1:0]         link_vec_i,
  input  logic [NUM_MON-1:0]         ext_link_i,
  input  logic [NUM_MON-1:0][AW-1:0] sel_phy_i,
  input  logic [NUM_MON-1:0]         sel_src_i,
  input  logic [NUM_MON-1:0]         int_en_i,
  input  logic                       raw_clr_we_i,
  input  logic [NUM_MON-1:0]         raw_clr_mask_i,
  output logic [NUM_MON-1:0]         raw_o,
  output logic [NUM_MON-1:0]         masked_o,
  output logic                       irq_o
);
  logic [NUM_MON-1:0] seen_q, cur, raw_q;

  for (genvar k = 0; k < NUM_MON; k++) begin : g_mon
    assign cur[k] = sel_src_i[k] ? ext_link_i[k] : link_vec_i[sel_phy_i[k]];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        seen_q[k] <= 1'b0;
        raw_q[k]  <= 1'b0;
      end else begin
        seen_q[k] <= cur[k];
        // new event wins over a same-cycle clear
        raw_q[k]  <= (raw_q[k] & ~(raw_clr_we_i & raw_clr_mask_i[k])) | (cur[k] ^ seen_q[k]);
      end
    end

    AST_RAW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      raw_o[k] && !(raw_clr_we_i && raw_clr_mask_i[k]) |=> raw_o[k]); // R9
  end

  assign raw_o    = raw_q;
  assign masked_o = raw_q & int_en_i;
  assign irq_o    = |masked_o;
endmodule

// File: rtl/mdio_link_poller.sv
module mdio_link_poller #(
  parameter int NUM_PHY  = 32,
  parameter int NUM_MON  = 2,
  parameter int DATA_W   = 16,
  parameter int STAT_REG = 1,
  parameter int LINK_BIT = 2,
  localparam int AW      = $clog2(NUM_PHY)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  output logic [AW-1:0]      req_phy_o,
  output logic [4:0]         req_reg_o,
  input  logic               resp_valid_i,
  input  logic               resp_ack_i,
  input  logic [DATA_W-1:0]  resp_data_i,
  input  logic               user_pending_i,
  input  logic               user_done_i,
  input  logic [AW-1:0]      user_phy_i,
  input  logic               user_ack_i,
  input  logic [NUM_MON-1:0] ext_link_i,
  output logic               link_irq_o
);
  import mlp_pkg::*;

  logic                       en_q;
  logic [NUM_MON-1:0][AW-1:0] sel_phy_q;
  logic [NUM_MON-1:0]         sel_src_q, int_en_q;
  logic                       upd_valid, upd_ack, upd_link;
  logic [AW-1:0]              upd_phy;
  logic [NUM_PHY-1:0]         alive, link;
  logic [NUM_MON-1:0]         raw, masked;
  logic                       alive_clr, raw_clr;

  assign alive_clr = reg_we_i && reg_addr_i == REG_AW'(A_ALIVE);
  assign raw_clr   = reg_we_i && reg_addr_i == REG_AW'(A_RAW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      sel_phy_q <= '0;
      sel_src_q <= '0;
      int_en_q  <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == REG_AW'(A_CTRL)) en_q <= reg_wdata_i[0];
      for (int k = 0; k < NUM_MON; k++) begin
        if (reg_addr_i == REG_AW'(A_SEL0 + k)) begin
          sel_phy_q[k] <= reg_wdata_i[AW-1:0];
          sel_src_q[k] <= reg_wdata_i[SEL_SRC_B];
          int_en_q[k]  <= reg_wdata_i[SEL_IEN_B];
        end
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_AW'(A_CTRL):   reg_rdata_o = REG_W'(en_q);
      REG_AW'(A_ALIVE):  reg_rdata_o = REG_W'(alive);
      REG_AW'(A_LINK):   reg_rdata_o = REG_W'(link);
      REG_AW'(A_RAW):    reg_rdata_o = REG_W'(raw);
      REG_AW'(A_MASKED): reg_rdata_o = REG_W'(masked);
      default: ;
    endcase
    for (int k = 0; k < NUM_MON; k++) begin
      if (reg_addr_i == REG_AW'(A_SEL0 + k)) begin
        reg_rdata_o[AW-1:0]      = sel_phy_q[k];
        reg_rdata_o[SEL_SRC_B]   = sel_src_q[k];
        reg_rdata_o[SEL_IEN_B]   = int_en_q[k];
      end
    end
  end

  mlp_scan_fsm #(
    .NUM_PHY(NUM_PHY), .STAT_REG(STAT_REG), .LINK_BIT(LINK_BIT), .DATA_W(DATA_W)
  ) u_scan (
    .clk_i, .rst_ni,
    .enable_i      (en_q),
    .user_pending_i,
    .req_valid_o, .req_ready_i, .req_phy_o, .req_reg_o,
    .resp_valid_i, .resp_ack_i, .resp_data_i,
    .upd_valid_o   (upd_valid),
    .upd_phy_o     (upd_phy),
    .upd_ack_o     (upd_ack),
    .upd_link_o    (upd_link)
  );

  mlp_status_vec #(.NUM_PHY(NUM_PHY)) u_vec (
    .clk_i, .rst_ni,
    .upd_valid_i (upd_valid),
    .upd_phy_i   (upd_phy),
    .upd_ack_i   (upd_ack),
    .upd_link_i  (upd_link),
    .user_done_i, .user_phy_i, .user_ack_i,
    .clr_we_i    (alive_clr),
    .clr_mask_i  (reg_wdata_i[NUM_PHY-1:0]),
    .alive_o     (alive),
    .link_o      (link)
  );

  mlp_link_monitor #(.NUM_PHY(NUM_PHY), .NUM_MON(NUM_MON)) u_mon (
    .clk_i, .rst_ni,
    .link_vec_i     (link),
    .ext_link_i,
    .sel_phy_i      (sel_phy_q),
    .sel_src_i      (sel_src_q),
    .int_en_i       (int_en_q),
    .raw_clr_we_i   (raw_clr),
    .raw_clr_mask_i (reg_wdata_i[NUM_MON-1:0]),
    .raw_o          (raw),
    .masked_o       (masked),
    .irq_o          (link_irq_o)
  );
endmodule

// File: tb/tb_mdio_link_poller.sv
module tb_mdio_link_poller;
  logic        clk_i = 0, rst_ni = 0;
  logic        reg_we_i = 0;
  logic [2:0]  reg_addr_i = 0;
  logic [31:0] reg_wdata_i = 0, reg_rdata_o;
  logic        req_valid_o, req_ready_i = 0;
  logic [4:0]  req_phy_o, req_reg_o;
  logic        resp_valid_i = 0, resp_ack_i = 0;
  logic [15:0] resp_data_i = 0;
  logic        user_pending_i = 0, user_done_i = 0, user_ack_i = 0;
  logic [4:0]  user_phy_i = 0;
  logic [1:0]  ext_link_i = 0;
  logic        link_irq_o;

  always #5 clk_i = ~clk_i;

  mdio_link_poller dut (.*);

  int vectors = 0, miscompares = 0;
  int acc_cnt = 0, resp_cnt = 0;
  logic [4:0] exp_q[$];
  bit   phy_present[32];
  bit   phy_linkup[32];
  bit   done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // driver: expected scan order, continuing across enable toggles
  int next_exp = 0;
  task automatic push_scan(int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(5'(next_exp));
      next_exp = (next_exp + 1) % 32;
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 0; reg_wdata_i = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wait_resp(int n);
    int target;
    target = resp_cnt + n;
    while (resp_cnt < target) @(negedge clk_i);
    wait_cyc(2);
  endtask

  // frame engine model + monitor
  initial begin
    int busy = 0;
    bit tog = 0;
    logic [4:0] cur = 0;
    bit  hold_pend = 0;
    logic [4:0] hold_phy = 0;
    forever begin
      @(negedge clk_i);
      resp_valid_i = 0;
      if (!rst_ni) continue;
      if (hold_pend) begin // R11
        chk("R11 hold valid", 32'(req_valid_o), 32'd1);
        chk("R11 hold addr", 32'(req_phy_o), 32'(hold_phy));
        hold_pend = 0;
      end
      if (busy > 0) begin
        req_ready_i = 0;
        busy--;
        if (busy == 0) begin
          resp_valid_i = 1;
          resp_ack_i   = phy_present[cur];
          resp_data_i  = !phy_present[cur] ? 16'hFFFF : (phy_linkup[cur] ? 16'h0004 : 16'hFFFB);
          resp_cnt++;
        end
      end else begin
        tog = !tog;
        req_ready_i = tog;
        if (req_valid_o && req_ready_i) begin
          logic [4:0] e;
          e = (exp_q.size() > 0) ? exp_q.pop_front() : 5'h1F;
          chk("R2 scan address", 32'(req_phy_o), 32'(e));
          chk("R2 status register", 32'(req_reg_o), 32'd1);
          cur = req_phy_o;
          busy = 3;
          acc_cnt++;
        end else if (req_valid_o) begin
          hold_pend = 1;
          hold_phy  = req_phy_o;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int snap;
    for (int i = 0; i < 32; i++) begin phy_present[i] = 0; phy_linkup[i] = 0; end
    phy_present[4] = 1; phy_linkup[4] = 1;
    phy_present[9] = 1; phy_linkup[9] = 0;
    push_scan(256);

    wait_cyc(3);
    rst_ni = 1;
    wait_cyc(1);
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d);
      chk("R1 reset value", d, 32'd0);
    end
    chk("R1 no request at reset", 32'(req_valid_o), 32'd0);
    wait_cyc(20);
    chk("R1 idle while disabled", 32'(acc_cnt), 32'd0);

    // entry0 watches phy 4 via polled link, irq on; entry1 watches phy 9, irq off
    wr(3'd5, 32'h0000_0084);
    wr(3'd6, 32'h0000_0009);
    rd(3'd5, d); chk("R8 entry0 readback", d, 32'h84);
    wr(3'd0, 32'd1);
    wait_resp(36);
    wr(3'd0, 32'd0);
    wait_cyc(20);

    rd(3'd1, d); chk("R4 alive after scan", d, 32'h0000_0210);
    rd(3'd2, d); chk("R3 link after scan", d, 32'h0000_0010);
    rd(3'd3, d); chk("R9 raw on phy4 link up", d, 32'h1);
    rd(3'd4, d); chk("R10 masked entry0", d, 32'h1);
    chk("R10 irq high", 32'(link_irq_o), 32'd1);

    snap = acc_cnt;
    wait_cyc(30);
    chk("R1 no polls after disable", 32'(acc_cnt), 32'(snap));

    wr(3'd1, 32'h0);
    rd(3'd1, d); chk("R6 write zero no effect", d, 32'h210);
    wr(3'd1, 32'h200);
    rd(3'd1, d); chk("R6 write one clears", d, 32'h010);

    @(negedge clk_i); user_done_i = 1; user_phy_i = 5'd20; user_ack_i = 1;
    @(negedge clk_i); user_done_i = 0;
    rd(3'd1, d); chk("R5 user ack sets alive", d, 32'h0010_0010);
    @(negedge clk_i); user_done_i = 1; user_phy_i = 5'd4; user_ack_i = 0;
    @(negedge clk_i); user_done_i = 0;
    rd(3'd1, d); chk("R5 user nack clears alive", d, 32'h0010_0000);

    wr(3'd3, 32'h0);
    rd(3'd3, d); chk("R9 zero write keeps raw", d, 32'h1);
    wr(3'd3, 32'h1);
    rd(3'd3, d); chk("R9 raw cleared", d, 32'h0);
    chk("R10 irq low after clear", 32'(link_irq_o), 32'd0);

    // entry1 to external source, irq on
    wr(3'd6, 32'h0000_00C9);
    wait_cyc(2);
    rd(3'd3, d); chk("R8 source switch no event", d, 32'h0);
    @(negedge clk_i); ext_link_i = 2'b10;
    wait_cyc(2);
    rd(3'd3, d); chk("R8 external link event", d, 32'h2);
    rd(3'd4, d); chk("R10 masked entry1", d, 32'h2);
    chk("R10 irq from entry1", 32'(link_irq_o), 32'd1);
    wr(3'd3, 32'h2);
    wr(3'd6, 32'h0000_0049);
    @(negedge clk_i); ext_link_i = 2'b00;
    wait_cyc(2);
    rd(3'd3, d); chk("R9 raw with irq off", d, 32'h2);
    rd(3'd4, d); chk("R10 masked gated off", d, 32'h0);
    chk("R10 irq gated off", 32'(link_irq_o), 32'd0);
    wr(3'd3, 32'h2);

    // R7: pending user transaction holds polling off
    phy_linkup[4] = 0;
    @(negedge clk_i); user_pending_i = 1;
    snap = acc_cnt;
    wr(3'd0, 32'd1);
    wait_cyc(40);
    chk("R7 no poll while user pending", 32'(acc_cnt), 32'(snap));
    @(negedge clk_i); user_pending_i = 0;
    wait_resp(40);
    wr(3'd0, 32'd0);
    wait_cyc(20);
    chk("R7 polling resumed", 32'(acc_cnt >= snap + 40), 32'd1);
    rd(3'd1, d); chk("R4 alive after second pass", d, 32'h0000_0210);
    rd(3'd2, d); chk("R3 link down after second pass", d, 32'h0);
    rd(3'd3, d); chk("R9 raw on phy4 link down", d, 32'h1);
    chk("R10 irq on link down", 32'(link_irq_o), 32'd1);

    done = 1;
    summary();
    $finish;
  end
endmodule